// File: doc/BRIEF.md
# Serial Receive Deframer with FIFO and DMA Request

This block turns an asynchronous serial input into stored characters. It watches the receive line at sixteen samples per bit, finds and confirms start bits, collects five to eight data bits least significant first, and checks the optional parity bit against one of four parity rules. It also checks the first stop bit. Each character is written into a sixteen-entry receive queue together with a parity-error flag and a framing-error flag. A reader drains the queue through a show-ahead read port.

A DMA engine is signalled by a request that is set in two cases. The first is when the queue fill reaches a selectable threshold. The second is when characters have been left unread while the line has been quiet for four character times. The request stays set until the engine acknowledges it. A character that arrives while the queue is full is dropped, and a sticky overrun flag records the loss.

The deframer is a five-state machine. The states are ST_IDLE, ST_START, ST_DATA, ST_PARITY and ST_STOP. The transitions are:
- ST_IDLE to ST_START when a tick sees the line low.
- ST_START to ST_IDLE on a false start, meaning the line is high at mid-bit.
- ST_START to ST_DATA on a confirmed start.
- ST_DATA to ST_PARITY after the last data bit when parity is on.
- ST_DATA to ST_STOP after the last data bit when parity is off.
- ST_PARITY to ST_STOP after the parity bit.
- ST_STOP to ST_IDLE after sampling the stop bit, which writes the character.

Top module: `uart_rx_dma`

## Requirements
- R1: The number of data bits follows `wlen_sel`: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Received bits appear right-aligned in `rd_data`, and the unused upper bits read 0.
- R2: Data bits are taken least significant bit first, each sampled at its centre, and the start bit is confirmed 8 ticks after the falling edge is seen.
- R3: When `par_en` is 1, a parity bit follows the data. `par_mode` selects the expected parity bit: 00 makes the count of ones (data plus parity) odd, 01 makes it even, 10 expects a constant 1, 11 expects a constant 0. A mismatch sets `rd_perr` for that character. When `par_en` is 0, no parity bit is expected and `rd_perr` reads 0.
- R4: A 0 sampled in the first stop bit sets `rd_ferr` for that character.
- R5: A low pulse on `rxd` that has ended before mid-bit is a false start. The block returns to idle and stores nothing.
- R6: Characters leave the queue in arrival order. `level` counts the stored entries, from 0 up to 16. A read while the queue is empty has no effect.
- R7: A character that completes while 16 entries are stored is discarded, the stored entries are unchanged, and `overrun` becomes 1 and stays 1 until reset.
- R8: `dma_req` is set when `level` becomes equal to or greater than the threshold chosen by `trig_sel`: 00 means 1, 01 means 4, 10 means 8, 11 means 14. `dma_req` is not set while `level` stays below the threshold.
- R9: `dma_req` is set when the queue is not empty and neither a stored character nor a read has occurred for 640 ticks (4 characters of 10 bits).
- R10: Once set, `dma_req` stays 1 until a cycle with `dma_ack` high clears it.
- R11: After reset, `level` is 0, `overrun` is 0 and `dma_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wlen_sel | input | 2 | Data-bit count select |
| par_en | input | 1 | Parity bit present and checked |
| par_mode | input | 2 | Parity rule select |
| trig_sel | input | 2 | DMA fill threshold select |
| rd_en | input | 1 | Pop the head entry |
| dma_ack | input | 1 | Clears the DMA request |
| rd_data | output | 8 | Head entry data, right-aligned |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky character-lost flag |
| dma_req | output | 1 | Receive DMA request |

## Verification
A deframer state machine that enters ST_DATA a tick early or late shifts every sampled bit. This shows in `rd_data` for the very next character, as a value shifted by one bit or with wrong upper bits. A wrong bit count or parity rule shows as a wrong `rd_perr` on the first character sent in that format. Queue pointer or count errors appear in `level` and in the order of read data within one character time. A timeout counter that is off, or a threshold edge detector that fails, shows on `dma_req` either about 640 ticks after the last character or on the character that crosses the threshold.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    function automatic int trig_level(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            2'b11: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       tick,
    input  logic [1:0] wlen_sel,
    input  logic       par_en,
    input  logic [1:0] par_mode,
    output logic       push,
    output rx_char_t   char_o
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);

    rx_state_t          st, st_n;
    logic [1:0]         sync;
    logic               rxd_s;
    logic [CW-1:0]      cnt;
    logic [3:0]         bit_idx;
    logic [CHAR_W-1:0]  shreg;
    logic               par_bit;
    logic [3:0]         nbits;
    logic [CHAR_W-1:0]  data_al;
    logic               ones;
    logic               exp_par;
    logic               bit_end;

    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end
    assign rxd_s = sync[1];

    assign nbits   = 4'd5 + {2'b00, wlen_sel};
    assign data_al = shreg >> (4'd8 - nbits);
    assign ones    = ^data_al;
    assign bit_end = tick && (cnt == BIT_LAST);

    always_comb begin
        unique case (par_mode)
            2'b00: exp_par = ~ones;
            2'b01: exp_par = ones;
            2'b10: exp_par = 1'b1;
            2'b11: exp_par = 1'b0;
        endcase
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:   if (tick && !rxd_s) st_n = ST_START;
            ST_START:  if (tick && cnt == HALF_LAST) st_n = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && bit_idx == nbits - 4'd1) st_n = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) st_n = ST_STOP;
            ST_STOP:   if (bit_end) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                end
                ST_START: cnt <= (cnt == HALF_LAST) ? '0 : cnt + 1'b1;
                ST_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt     <= '0;
                        shreg   <= {rxd_s, shreg[CHAR_W-1:1]};
                        bit_idx <= bit_idx + 4'd1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (cnt == BIT_LAST) begin
                        cnt     <= '0;
                        par_bit <= rxd_s;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: cnt <= (cnt == BIT_LAST) ? '0 : cnt + 1'b1;
                default: cnt <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push   <= 1'b0;
            char_o <= '0;
        end else begin
            push <= 1'b0;
            if (st == ST_STOP && bit_end) begin
                push        <= 1'b1;
                char_o.data <= data_al;
                char_o.perr <= par_en && (par_bit != exp_par);
                char_o.ferr <= !rxd_s;
            end
        end
    end

    // R4
    push_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(st) == ST_STOP && st == ST_IDLE));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_char_t                   din,
    input  logic                       pop,
    output rx_char_t                   dout,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       overrun
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic            full, empty, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (push && full) overrun <= 1'b1;
        end
    end

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + LW'(1)) ||
        (level == $past(level) - LW'(1)));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/uart_rx_dmareq.sv
module uart_rx_dmareq
    import uart_rx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int OSR       = 16,
    parameter int CHAR_BITS = 10,
    parameter int TMO_CHARS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [$clog2(DEPTH):0] level,
    input  logic [1:0]             trig_sel,
    input  logic                   rx_evt,
    input  logic                   rd_evt,
    input  logic                   ack,
    output logic                   req
);

    localparam int LW    = $clog2(DEPTH) + 1;
    localparam int LIMIT = TMO_CHARS * CHAR_BITS * OSR;
    localparam int TW    = $clog2(LIMIT + 1);

    logic [LW-1:0] trig;
    logic          thr, thr_q, fire, quiet_rst, set_req;
    logic [TW-1:0] tcnt;

    assign trig      = LW'(trig_level(trig_sel));
    assign thr       = (level >= trig);
    assign quiet_rst = rx_evt || rd_evt || (level == '0);
    assign fire      = tick && !quiet_rst && (tcnt == TW'(LIMIT - 1));
    assign set_req   = (thr && !thr_q) || fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt  <= '0;
            thr_q <= 1'b0;
            req   <= 1'b0;
        end else begin
            thr_q <= thr;
            if (quiet_rst)                         tcnt <= '0;
            else if (tick && tcnt != TW'(LIMIT))   tcnt <= tcnt + 1'b1;
            if (set_req)  req <= 1'b1;
            else if (ack) req <= 1'b0;
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    // R9
    tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (level != '0));

endmodule

// File: rtl/uart_rx_dma.sv
module uart_rx_dma
    import uart_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DEPTH     = 16,
    parameter int CHAR_BITS = 10,
    parameter int TMO_CHARS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rxd,
    input  logic                    tick,
    input  logic [1:0]              wlen_sel,
    input  logic                    par_en,
    input  logic [1:0]              par_mode,
    input  logic [1:0]              trig_sel,
    input  logic                    rd_en,
    input  logic                    dma_ack,
    output logic [CHAR_W-1:0]       rd_data,
    output logic                    rd_perr,
    output logic                    rd_ferr,
    output logic [$clog2(DEPTH):0]  level,
    output logic                    overrun,
    output logic                    dma_req
);

    rx_char_t rx_char, head;
    logic     rx_push, rd_evt;

    assign rd_evt  = rd_en && (level != '0);
    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;

    uart_rx_deframer #(.OSR(OSR)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .tick     (tick),
        .wlen_sel (wlen_sel),
        .par_en   (par_en),
        .par_mode (par_mode),
        .push     (rx_push),
        .char_o   (rx_char)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .din     (rx_char),
        .pop     (rd_en),
        .dout    (head),
        .level   (level),
        .overrun (overrun)
    );

    uart_rx_dmareq #(
        .DEPTH     (DEPTH),
        .OSR       (OSR),
        .CHAR_BITS (CHAR_BITS),
        .TMO_CHARS (TMO_CHARS)
    ) u_dmareq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .level    (level),
        .trig_sel (trig_sel),
        .rx_evt   (rx_push),
        .rd_evt   (rd_evt),
        .ack      (dma_ack),
        .req      (dma_req)
    );

endmodule

// File: tb/uart_rx_dma_test.sv
`timescale 1ns/100ps
module uart_rx_dma_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen_sel = 2'b11;
    logic       par_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic [1:0] trig_sel = 2'b11;
    logic       rd_en = 1'b0;
    logic       dma_ack = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, overrun, dma_req;
    logic [4:0] level;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    // fields: wlen(2) pen(1) pmode(2) badpar(1) stop0(1) data(8)
    localparam logic [14:0] VEC [0:8] = '{
        {2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 8'hA5},
        {2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 8'hF3},
        {2'b10, 1'b1, 2'b01, 1'b0, 1'b0, 8'h55},
        {2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 8'h81},
        {2'b01, 1'b1, 2'b10, 1'b0, 1'b0, 8'h2A},
        {2'b01, 1'b1, 2'b10, 1'b1, 1'b0, 8'h2A},
        {2'b11, 1'b1, 2'b11, 1'b0, 1'b0, 8'hFF},
        {2'b11, 1'b0, 2'b00, 1'b0, 1'b1, 8'h3C},
        {2'b10, 1'b1, 2'b00, 1'b1, 1'b0, 8'h0A}
    };

    uart_rx_dma uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
        .wlen_sel(wlen_sel), .par_en(par_en), .par_mode(par_mode),
        .trig_sel(trig_sel), .rd_en(rd_en), .dma_ack(dma_ack),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .level(level), .overrun(overrun), .dma_req(dma_req)
    );

    initial forever #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk iff tick);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        wait_ticks(16);
    endtask

    function automatic logic par_of(input int nb, input logic [1:0] pm, input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (pm)
            2'b00:   return (ones % 2) == 0;
            2'b01:   return (ones % 2) == 1;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_char(input logic [7:0] d, input logic badpar, input logic stop0);
        int nb = 5 + int'(wlen_sel);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (par_en) send_bit(par_of(nb, par_mode, d) ^ badpar);
        send_bit(!stop0);
        if (stop0) send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack_one();
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "level", int'(level), 0);
        chk("R11", "overrun", int'(overrun), 0);
        chk("R11", "dma_req", int'(dma_req), 0);

        // vector table: formats, parity modes, framing
        for (int v = 0; v < 9; v++) begin
            logic [14:0] e;
            int nb;
            logic [7:0] mask;
            e = VEC[v];
            @(negedge clk);
            wlen_sel = e[14:13];
            par_en   = e[12];
            par_mode = e[11:10];
            nb   = 5 + int'(e[14:13]);
            mask = 8'((1 << nb) - 1);
            send_char(e[7:0], e[9], e[8]);
            chk("R6", "level after char", int'(level), 1);
            chk("R1 R2", "data", int'(rd_data), int'(e[7:0] & mask));
            chk("R3", "perr", int'(rd_perr), int'(e[12] & e[9]));
            chk("R4", "ferr", int'(rd_ferr), int'(e[8]));
            pop_one();
            chk("R6", "level after read", int'(level), 0);
        end
        chk("R8", "no request below threshold", int'(dma_req), 0);

        // R6 read of empty queue has no effect
        pop_one();
        chk("R6", "empty read level", int'(level), 0);

        // R5 false start
        @(negedge clk);
        wlen_sel = 2'b11; par_en = 1'b0; par_mode = 2'b00;
        rxd = 1'b0;
        wait_ticks(4);
        rxd = 1'b1;
        wait_ticks(40);
        chk("R5", "level after glitch", int'(level), 0);
        send_char(8'h6B, 1'b0, 1'b0);
        chk("R5", "data after glitch", int'(rd_data), 8'h6B);
        pop_one();

        // R8 threshold of 1
        trig_sel = 2'b00;
        send_char(8'h11, 1'b0, 1'b0);
        chk("R8", "req at level 1", int'(dma_req), 1);
        ack_one();
        chk("R10", "req cleared by ack", int'(dma_req), 0);
        pop_one();

        // R8 threshold of 4, R10 hold, R6 order
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) send_char(8'(8'h40 + i), 1'b0, 1'b0);
        chk("R8", "req at level 3", int'(dma_req), 0);
        send_char(8'h43, 1'b0, 1'b0);
        chk("R8", "req at level 4", int'(dma_req), 1);
        wait_ticks(50);
        chk("R10", "req held without ack", int'(dma_req), 1);
        ack_one();
        chk("R10", "req cleared", int'(dma_req), 0);
        chk("R6", "level 4", int'(level), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R6", "order", int'(rd_data), 8'h40 + i);
            pop_one();
        end

        // R9 character timeout
        trig_sel = 2'b11;
        send_char(8'h77, 1'b0, 1'b0);
        chk("R9", "no req right after char", int'(dma_req), 0);
        wait_ticks(600);
        chk("R9", "no req before 640 ticks", int'(dma_req), 0);
        wait_ticks(60);
        chk("R9", "req after timeout", int'(dma_req), 1);
        ack_one();
        chk("R10", "timeout req cleared", int'(dma_req), 0);
        pop_one();
        chk("R6", "level after timeout read", int'(level), 0);

        // R7 overrun
        for (int i = 0; i < 17; i++) send_char(8'(i), 1'b0, 1'b0);
        chk("R7", "level full", int'(level), 16);
        chk("R7", "overrun set", int'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            chk("R7", "kept entry", int'(rd_data), i);
            pop_one();
        end
        chk("R7", "level drained", int'(level), 0);
        chk("R7", "overrun sticky", int'(overrun), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule